// File: doc/BRIEF.md
# LIN Break Length Detector

This block watches an asynchronous serial receive line, passes it through a two-stage synchronizer and measures every low period in sample ticks. The ticks come from the clock through a divider of 8 times a power of two, with the power picked by a select input. At the end of each low period the measured length is published. If the low period was at least 11 nominal bit periods long and did not overflow, a one-cycle break strobe is raised.

The length counter is 12 bits wide. A low period that runs past its range does not wrap. It raises a sticky overflow error instead, and the counter holds at its top value. After a valid break, the block times the falling edges of the following 0x55 sync byte. It turns the span of eight bit periods into a new nominal bit period, which also sets the threshold for the next break. The select value should suit the baud rate range to be detected. For example, at 19.2 kbit/s with select 0 and a 24 MHz clock, the longest measurable break is about 26 bit times.

Top module: `lin_brk_detector`

## Requirements
- R1: With select value s, a sample tick occurs every 8*2^s clock cycles. The tick divider restarts on a falling edge seen while idle, so a low period of L clocks (edge to edge) counts floor((L-1)/(8*2^s)) ticks.
- R2: The select input is captured only while the synchronized line is high. Changing it during a low period does not change the tick rate used for that period.
- R3: When the line returns high after a low period that began in the idle state, `brk_len_o` is loaded with the tick count of that period. The new value is visible 3 clocks after the rising edge at `rx_i`.
- R4: If a low period needs more than 4095 ticks, `ovf_err_o` is set, the length holds at 4095 and no break strobe follows.
- R5: `ovf_err_o` stays set until a clock cycle with `ovf_clr_i` high. If a new overflow occurs in the same cycle as a clear, the flag stays set.
- R6: `brk_det_o` is a one-cycle pulse that appears together with the length update. It appears only when the length is at least 11 times `bit_per_o` and the period did not overflow.
- R7: A low period shorter than the break threshold gives no strobe and starts no sync measurement. `bit_per_o` stays unchanged.
- R8: After a valid break, the ticks from the first to the fifth falling edge are counted. At the fifth edge, `bit_per_o` is loaded with that count divided by 8, rounded down.
- R9: After reset, `brk_len_o` is 0, `brk_det_o` and `ovf_err_o` are 0, and `bit_per_o` holds the nominal value 13.
- R10: If the sync span count reaches 4095 ticks before the fifth falling edge, the measurement is abandoned and `bit_per_o` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line |
| presc_sel_i | input | 2 | Tick divider exponent s (divide by 8*2^s) |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| brk_len_o | output | 12 | Tick length of the most recent low period |
| brk_det_o | output | 1 | One-cycle strobe on a valid break |
| ovf_err_o | output | 1 | Sticky length overflow error |
| bit_per_o | output | 9 | Nominal bit period in ticks |

## Verification
The detector is driven with the following low periods:
- a break just above the threshold, which separates an accepted break from a rejected one;
- a low period well below the threshold, which shows that short lows update the length but never arm the sync timer;
- a break at the larger divider with the select changed mid-low, which tells a latched select from a live one;
- a low period past the counter range, which exercises saturation and the sticky flag.

Sync bytes are sent at two bit periods, with bit lengths chosen so that the tick phase cannot move the result. A sync byte that stops after one edge must leave the bit period untouched.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BRK   = 2'd1,
    ST_SWAIT = 2'd2,
    ST_SMEAS = 2'd3
  } lbd_st_e;
endpackage

// File: rtl/lbd_sync.sv
module lbd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign fall_o = s3_q & ~s2_q;
  assign rise_o = ~s3_q & s2_q;
endmodule

// File: rtl/lbd_tick.sv
module lbd_tick #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int SEL_MAX = (1 << SEL_W) - 1;
  localparam int PC_W    = 3 + SEL_MAX;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [PC_W-1:0]  pc_q, pc_d, lim;

  assign lim    = {PC_W{1'b1}} >> (SEL_MAX - int'(sel_q));
  assign tick_o = (pc_q >= lim);

  always_comb begin
    sel_d = sel_q;
    if (lvl_i) sel_d = sel_i;
    if (restart_i)   pc_d = '0;
    else if (tick_o) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      pc_q  <= '0;
    end else begin
      sel_q <= sel_d;
      pc_q  <= pc_d;
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_i |=> $stable(sel_q));
endmodule

// File: rtl/lbd_meas.sv
module lbd_meas
  import lbd_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int NOM_BP  = 13,
  parameter int THR_MUL = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             tick_i,
  input  logic             ovf_clr_i,
  output logic             restart_o,
  output logic [LEN_W-1:0] brk_len_o,
  output logic             brk_det_o,
  output logic             ovf_err_o,
  output logic [LEN_W-4:0] bit_per_o
);
  localparam int BP_W  = LEN_W - 3;
  localparam int THR_W = LEN_W + 4;

  lbd_st_e          st_q, st_d;
  logic [LEN_W-1:0] len_q, len_d, span_q, span_d, blen_q, blen_d;
  logic [1:0]       edg_q, edg_d;
  logic [BP_W-1:0]  bp_q, bp_d;
  logic             det_q, det_d, ovf_q, ovf_d, bovf_q, bovf_d;
  logic [THR_W-1:0] thr;

  assign thr       = THR_W'(THR_MUL) * THR_W'(bp_q);
  assign restart_o = fall_i && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    len_d  = len_q;
    span_d = span_q;
    blen_d = blen_q;
    edg_d  = edg_q;
    bp_d   = bp_q;
    bovf_d = bovf_q;
    det_d  = 1'b0;
    ovf_d  = ovf_clr_i ? 1'b0 : ovf_q;
    case (st_q)
      ST_IDLE: if (fall_i) begin
        st_d   = ST_BRK;
        len_d  = '0;
        bovf_d = 1'b0;
      end
      ST_BRK: if (rise_i) begin
        blen_d = len_q;
        if (!bovf_q && (THR_W'(len_q) >= thr)) begin
          det_d = 1'b1;
          st_d  = ST_SWAIT;
        end else begin
          st_d = ST_IDLE;
        end
      end else if (tick_i) begin
        if (len_q == '1) begin
          ovf_d  = 1'b1;
          bovf_d = 1'b1;
        end else begin
          len_d = len_q + 1'b1;
        end
      end
      ST_SWAIT: if (fall_i) begin
        st_d   = ST_SMEAS;
        span_d = '0;
        edg_d  = '0;
      end
      ST_SMEAS: if (fall_i) begin
        if (edg_q == 2'd3) begin
          bp_d = span_q[LEN_W-1:3];
          st_d = ST_IDLE;
        end else begin
          edg_d = edg_q + 1'b1;
        end
      end else if (tick_i) begin
        if (span_q == '1) st_d = ST_IDLE;
        else              span_d = span_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      span_q <= '0;
      blen_q <= '0;
      edg_q  <= '0;
      bp_q   <= BP_W'(NOM_BP);
      det_q  <= 1'b0;
      ovf_q  <= 1'b0;
      bovf_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      span_q <= span_d;
      blen_q <= blen_d;
      edg_q  <= edg_d;
      bp_q   <= bp_d;
      det_q  <= det_d;
      ovf_q  <= ovf_d;
      bovf_q <= bovf_d;
    end
  end

  assign brk_len_o = blen_q;
  assign brk_det_o = det_q;
  assign ovf_err_o = ovf_q;
  assign bit_per_o = bp_q;

  p_ovf_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (len_q == '1));
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  p_det_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |-> (THR_W'(blen_q) >= thr));
  p_det_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> !det_q);
  p_bp_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_q) |-> $past(st_q == ST_SMEAS));
endmodule

// File: rtl/lin_brk_detector.sv
module lin_brk_detector #(
  parameter int LEN_W   = 12,
  parameter int SEL_W   = 2,
  parameter int NOM_BP  = 13,
  parameter int THR_MUL = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             ovf_clr_i,
  output logic [LEN_W-1:0] brk_len_o,
  output logic             brk_det_o,
  output logic             ovf_err_o,
  output logic [LEN_W-4:0] bit_per_o
);
  logic lvl, fall, rise, tick, restart;

  lbd_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .lvl_o  (lvl),
    .fall_o (fall),
    .rise_o (rise)
  );

  lbd_tick #(.SEL_W(SEL_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl),
    .restart_i (restart),
    .sel_i     (presc_sel_i),
    .tick_o    (tick)
  );

  lbd_meas #(.LEN_W(LEN_W), .NOM_BP(NOM_BP), .THR_MUL(THR_MUL)) u_meas (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_i    (fall),
    .rise_i    (rise),
    .tick_i    (tick),
    .ovf_clr_i (ovf_clr_i),
    .restart_o (restart),
    .brk_len_o (brk_len_o),
    .brk_det_o (brk_det_o),
    .ovf_err_o (ovf_err_o),
    .bit_per_o (bit_per_o)
  );
endmodule

// File: tb/lin_brk_detector_bench.sv
`timescale 1ns/1ps
module lin_brk_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       clr = 1'b0;
  logic [11:0] brk_len;
  logic        brk_det, ovf_err;
  logic [8:0]  bit_per;

  int n_chk = 0;
  int n_fail = 0;
  int det_cnt = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lin_brk_detector u_lin_brk_detector (
    .clk (clk), .rst_n (rst_n), .rx_i (rx), .presc_sel_i (sel),
    .ovf_clr_i (clr), .brk_len_o (brk_len), .brk_det_o (brk_det),
    .ovf_err_o (ovf_err), .bit_per_o (bit_per)
  );

  // behavioural reference model
  int m_s1, m_s2, m_s3, m_sel, m_pc, m_st, m_len, m_bovf, m_ovf;
  int m_blen, m_det, m_bp, m_span, m_edges;

  always @(posedge clk) begin
    int fall, rise, lim, tick, rst_pc;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_s3 = 1; m_sel = 0; m_pc = 0; m_st = 0;
      m_len = 0; m_bovf = 0; m_ovf = 0; m_blen = 0; m_det = 0;
      m_bp = 13; m_span = 0; m_edges = 0;
    end else begin
      fall = (m_s3 == 1 && m_s2 == 0) ? 1 : 0;
      rise = (m_s3 == 0 && m_s2 == 1) ? 1 : 0;
      lim = (8 << m_sel) - 1;
      tick = (m_pc >= lim) ? 1 : 0;
      rst_pc = (fall == 1 && m_st == 0) ? 1 : 0;
      m_pc = (rst_pc == 1 || tick == 1) ? 0 : m_pc + 1;
      if (m_s2 == 1) m_sel = int'(sel);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(rx);
      m_det = 0;
      if (clr) m_ovf = 0;
      case (m_st)
        0: if (fall == 1) begin m_st = 1; m_len = 0; m_bovf = 0; end
        1: if (rise == 1) begin
             m_blen = m_len;
             if (m_bovf == 0 && m_len >= 11 * m_bp) begin m_det = 1; m_st = 2; end
             else m_st = 0;
           end else if (tick == 1) begin
             if (m_len == 4095) begin m_ovf = 1; m_bovf = 1; end
             else m_len = m_len + 1;
           end
        2: if (fall == 1) begin m_st = 3; m_span = 0; m_edges = 0; end
        default: if (fall == 1) begin
             if (m_edges == 3) begin m_bp = m_span / 8; m_st = 0; end
             else m_edges = m_edges + 1;
           end else if (tick == 1) begin
             if (m_span == 4095) m_st = 0;
             else m_span = m_span + 1;
           end
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (brk_det) det_cnt++;
      check("R3 brk_len_o vs model", int'(brk_len), m_blen);
      check("R6 brk_det_o vs model", int'(brk_det), m_det);
      check("R4 ovf_err_o vs model", int'(ovf_err), m_ovf);
      check("R8 bit_per_o vs model", int'(bit_per), m_bp);
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic v, input int n);
    rx = v;
    wait_clk(n);
  endtask

  // 0x55 sync byte, LSB first, framed by start and stop bits
  task automatic sync_byte(input int b);
    drive(1'b0, b);
    for (int k = 0; k < 8; k++) drive(((k % 2) == 0) ? 1'b1 : 1'b0, b);
    drive(1'b1, b);
  endtask

  int d0;

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    check("R9 reset brk_len", int'(brk_len), 0);
    check("R9 reset brk_det", int'(brk_det), 0);
    check("R9 reset ovf", int'(ovf_err), 0);
    check("R9 reset bit_per", int'(bit_per), 13);
    drive(1'b1, 50);

    // valid break at select 0, then sync byte of 108 clocks per bit
    d0 = det_cnt;
    drive(1'b0, 1200);
    drive(1'b1, 10);
    check("R1/R3 length of 1200-clock low", int'(brk_len), 149);
    check("R6 strobe on valid break", det_cnt - d0, 1);
    drive(1'b1, 190);
    sync_byte(108);
    drive(1'b1, 300);
    check("R8 bit period from sync", int'(bit_per), 13);

    // short low: rejected, sync-like toggling ignored
    d0 = det_cnt;
    drive(1'b0, 800);
    drive(1'b1, 10);
    check("R7 length of short low", int'(brk_len), 99);
    check("R7 no strobe on short low", det_cnt - d0, 0);
    drive(1'b1, 100);
    sync_byte(60);
    drive(1'b1, 200);
    check("R7 bit period unchanged", int'(bit_per), 13);
    check("R7 last short low length", int'(brk_len), 7);

    // select 1, changed to 0 during the low
    sel = 2'd1;
    drive(1'b1, 50);
    d0 = det_cnt;
    drive(1'b0, 1000);
    sel = 2'd0;
    drive(1'b0, 1400);
    sel = 2'd1;
    drive(1'b0, 100);
    drive(1'b1, 10);
    check("R2 latched select gives length", int'(brk_len), 156);
    check("R6 strobe at select 1", det_cnt - d0, 1);
    drive(1'b1, 190);
    sync_byte(200);
    drive(1'b1, 300);
    check("R8 bit period at select 1", int'(bit_per), 12);

    // overflow at select 0
    sel = 2'd0;
    drive(1'b1, 50);
    d0 = det_cnt;
    drive(1'b0, 33000);
    check("R4 flag set during long low", int'(ovf_err), 1);
    drive(1'b1, 10);
    check("R4 length saturated", int'(brk_len), 4095);
    check("R4 no strobe on overflow", det_cnt - d0, 0);
    drive(1'b1, 100);
    check("R5 flag held without clear", int'(ovf_err), 1);
    clr = 1'b1;
    wait_clk(1);
    clr = 1'b0;
    wait_clk(1);
    check("R5 flag cleared", int'(ovf_err), 0);

    // abandoned sync measurement
    d0 = det_cnt;
    drive(1'b0, 1200);
    drive(1'b1, 100);
    check("R6 strobe before abandoned sync", det_cnt - d0, 1);
    drive(1'b0, 100);
    drive(1'b1, 33000);
    check("R10 bit period kept after span limit", int'(bit_per), 12);
    sync_byte(108);
    drive(1'b1, 200);
    check("R10 later sync without break ignored", int'(bit_per), 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 200000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule